// File: doc/BRIEF.md
# Descriptor entry list walker

This block traverses the chain of variable-length entries stored in a descriptor ROM after its fixed 22-byte header. A single `start` pulse latches the total ROM size. The walker then fetches bytes through a synchronous indexed read port and decodes the two-byte header of each entry. It hands one record per entry to a downstream consumer over a valid/ready handshake.

Each entry begins with a length byte, which counts the two header bytes, followed by a flags byte. The flags byte carries a 6-bit index, a disable bit and a type bit. Port entries yield a link number, a dual-link flag and a partner port number. Generic entries with index 1 or 2 mark the location and size of a vendor or device name string. A malformed chain stops the walk with an error code. A chain that reaches the ROM size exactly finishes with a done pulse.

Top module: `entry_walker`

## Requirements
- R1: After reset `rec_valid`, `done` and `err` are low. A `start` pulse in the idle state latches `rom_size` and begins the walk at byte offset 22. If 22 is not below the size, `done` pulses with no record issued.
- R2: Entry byte 0 is the entry length, header included. In entry byte 1, bits 5:0 are the index reported on `rec_index`, bit 6 is the disable flag and bit 7 is the type (1 = port, 0 = generic).
- R3: After an entry is handed on, the position advances by its length. When the position reaches the latched size, `done` pulses for one cycle. `done` and `err` never pulse together.
- R4: When the position is the last byte of the ROM (position + 1 = size), the walk stops with an `err` pulse and `err_code` = 1.
- R5: When position + length exceeds the size, the walk stops with `err_code` = 2. The check on R4 takes priority. No read is ever issued at or beyond the latched size.
- R6: A length byte of zero stops the walk with `err_code` = 3, unless R4 or R5 applies first.
- R7: A port entry with the disable flag set yields a record of kind 3 carrying its index. Link, dual and partner fields read zero for it, and its remaining bytes are not decoded.
- R8: An enabled port entry whose length is not 8 stops the walk with `err_code` = 4 and yields no record for that entry.
- R9: An enabled 8-byte port entry yields a record of kind 4. `rec_link` is bit 4 of entry byte 2, `rec_dual` is bit 7 of entry byte 2, and `rec_partner` is bits 5:0 of entry byte 3.
- R10: A generic entry yields kind 1 for index 1 (vendor name), kind 2 for index 2 (device name) and kind 0 otherwise. For kinds 1 and 2, `rec_str_ofs` is the entry position + 2 and `rec_str_len` is the length − 2. For all other kinds both string fields are zero.
- R11: A record stays valid and unchanged until `rec_ready` is high. Records leave in list order, one per entry.
- R12: A `start` pulse during a walk is ignored, and so is any `rom_size` change during a walk. After an error, no further record and no `done` appear until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (honoured when idle) |
| rom_size | input | ADDR_W | Total ROM size in bytes, latched at start |
| rd_en | output | 1 | ROM read strobe |
| rd_addr | output | ADDR_W | ROM byte address |
| rd_data | input | 8 | ROM byte, valid one cycle after `rd_en` |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_kind | output | 3 | 0 other generic, 1 vendor name, 2 device name, 3 disabled port, 4 port |
| rec_index | output | 6 | Entry index |
| rec_link | output | 1 | Port link number |
| rec_dual | output | 1 | Port has a dual-link partner |
| rec_partner | output | 6 | Dual-link partner port number |
| rec_str_ofs | output | ADDR_W | Byte offset of the name string |
| rec_str_len | output | 8 | Name string length |
| done | output | 1 | One-cycle pulse: list finished cleanly |
| err | output | 1 | One-cycle pulse: list malformed |
| err_code | output | 3 | Cause of the last error, held until the next start |

## Verification
The bench builds the walker with ADDR_W = 9 and keeps the 22-byte start offset and the 8-byte port length at their defaults. A 512-byte ROM image is then enough to place an entry so that it ends exactly on the size, straddles it, or leaves a lone trailing byte, which reaches every abort rule with short lists. Starting with a size at or below the header size covers the empty walk. A pseudo-random ready pattern together with a second start pulse during a long list covers the record hold and the rule that a busy walker ignores a new start.

// File: rtl/ewk_pkg.sv
// Shared encodings for the descriptor entry list walker.
// Assumes one ROM byte per address and the fixed entry header layout.
package ewk_pkg;
    localparam int BYTE_W       = 8;
    localparam int IDX_W        = 6;
    localparam int HDR_DIS_BIT  = 6;
    localparam int HDR_TYPE_BIT = 7;
    localparam int LINK_BIT     = 4;
    localparam int DUAL_BIT     = 7;

    typedef enum logic [2:0] {
        K_GEN_OTHER = 3'd0,
        K_VENDOR    = 3'd1,
        K_DEVICE    = 3'd2,
        K_PORT_OFF  = 3'd3,
        K_PORT      = 3'd4
    } ewk_kind_e;

    typedef enum logic [2:0] {
        E_NONE     = 3'd0,
        E_LAST     = 3'd1,
        E_OVERRUN  = 3'd2,
        E_ZERO     = 3'd3,
        E_PORTLEN  = 3'd4
    } ewk_err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_POS, ST_LEN, ST_HDR, ST_B2, ST_B3, ST_EMIT
    } ewk_state_e;
endpackage

// File: rtl/ewk_len_rules.sv
// Length-rule checker: judges an entry from its position, its length byte
// and the ROM size. The rules are checked in a fixed order: lone last byte,
// then overrun, then zero length.
// Assumes pos < size (the caller only asks while inside the ROM).
module ewk_len_rules
    import ewk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] pos,
    input  logic [ADDR_W-1:0] size,
    input  logic [BYTE_W-1:0] len,
    output ewk_err_e          code
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] next_pos;
    logic [SUM_W-1:0] one_past;

    // Compute entry end and the byte after the header start, one bit wider
    always_comb begin
        next_pos = {1'b0, pos} + SUM_W'(len);
        one_past = {1'b0, pos} + SUM_W'(1);
    end

    // Pick the first rule that is broken
    always_comb begin
        if (one_past == {1'b0, size})
            code = E_LAST;
        else if (next_pos > {1'b0, size})
            code = E_OVERRUN;
        else if (len == '0)
            code = E_ZERO;
        else
            code = E_NONE;
    end
endmodule

// File: rtl/ewk_walker.sv
// Byte fetch sequencer: walks the entry chain one ROM byte per read and
// keeps the bytes of the current entry in registers for record building.
// Assumes the ROM returns rd_data one cycle after rd_en.
module ewk_walker
    import ewk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int START_OFS = 22,
    parameter int PORT_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rom_size,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              can_load,
    output logic              ld,
    output logic [ADDR_W-1:0] pos_o,
    output logic [BYTE_W-1:0] len_o,
    output logic [BYTE_W-1:0] hdr_o,
    output logic [BYTE_W-1:0] b2_o,
    output logic [BYTE_W-1:0] b3_o,
    output logic              done,
    output logic              err,
    output ewk_err_e          err_code
);
    localparam logic [ADDR_W-1:0] START_A  = ADDR_W'(START_OFS);
    localparam logic [BYTE_W-1:0] PORT_L   = BYTE_W'(PORT_LEN);

    ewk_state_e        state;
    logic [ADDR_W-1:0] pos;
    logic [ADDR_W-1:0] size_q;
    logic [BYTE_W-1:0] len_q;
    logic [BYTE_W-1:0] hdr_q;
    logic [BYTE_W-1:0] b2_q;
    logic [BYTE_W-1:0] b3_q;
    ewk_err_e          len_code;
    logic              hdr_port;
    logic              hdr_off;

    ewk_len_rules #(.ADDR_W(ADDR_W)) i_len_rules (
        .pos  (pos),
        .size (size_q),
        .len  (rd_data),
        .code (len_code)
    );

    // Decode the flags byte as it arrives from the ROM
    always_comb begin
        hdr_port = rd_data[HDR_TYPE_BIT];
        hdr_off  = rd_data[HDR_DIS_BIT];
    end

    // Issue the ROM read for the next byte of the entry
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = pos;
        unique case (state)
            ST_POS: begin
                rd_en   = (pos < size_q);
                rd_addr = pos;
            end
            ST_LEN: begin
                rd_en   = (len_code == E_NONE);
                rd_addr = pos + ADDR_W'(1);
            end
            ST_HDR: begin
                rd_en   = hdr_port && !hdr_off && (len_q == PORT_L);
                rd_addr = pos + ADDR_W'(2);
            end
            ST_B2: begin
                rd_en   = 1'b1;
                rd_addr = pos + ADDR_W'(3);
            end
            default: begin
                rd_en   = 1'b0;
                rd_addr = pos;
            end
        endcase
    end

    // Hand the record over when the holding register can take it
    always_comb ld = (state == ST_EMIT) && can_load;

    // Step through the chain, capture entry bytes and raise end pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pos      <= '0;
            size_q   <= '0;
            len_q    <= '0;
            hdr_q    <= '0;
            b2_q     <= '0;
            b3_q     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= E_NONE;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        size_q   <= rom_size;
                        pos      <= START_A;
                        err_code <= E_NONE;
                        state    <= ST_POS;
                    end
                end
                ST_POS: begin
                    if (pos >= size_q) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    len_q <= rd_data;
                    if (len_code != E_NONE) begin
                        err      <= 1'b1;
                        err_code <= len_code;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    hdr_q <= rd_data;
                    if (hdr_port && !hdr_off) begin
                        if (len_q != PORT_L) begin
                            err      <= 1'b1;
                            err_code <= E_PORTLEN;
                            state    <= ST_IDLE;
                        end else begin
                            state <= ST_B2;
                        end
                    end else begin
                        state <= ST_EMIT;
                    end
                end
                ST_B2: begin
                    b2_q  <= rd_data;
                    state <= ST_B3;
                end
                ST_B3: begin
                    b3_q  <= rd_data;
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (can_load) begin
                        pos   <= pos + ADDR_W'(len_q);
                        state <= ST_POS;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pos_o = pos;
        len_o = len_q;
        hdr_o = hdr_q;
        b2_o  = b2_q;
        b3_o  = b3_q;
    end

    // R5
    rd_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < size_q));

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != E_NONE));

    // R3
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> $stable(size_q));

    // R8
    port_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && hdr_q[HDR_TYPE_BIT] && !hdr_q[HDR_DIS_BIT]) |-> (len_q == PORT_L));
endmodule

// File: rtl/ewk_field_dec.sv
// Record field decoder: turns the captured bytes of one entry into the
// record fields. Fields that do not apply to a kind read zero.
// Assumes b2/b3 are only meaningful for enabled port entries.
module ewk_field_dec
    import ewk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] pos,
    input  logic [BYTE_W-1:0] len,
    input  logic [BYTE_W-1:0] hdr,
    input  logic [BYTE_W-1:0] b2,
    input  logic [BYTE_W-1:0] b3,
    output ewk_kind_e         kind,
    output logic [IDX_W-1:0]  index,
    output logic              link,
    output logic              dual,
    output logic [IDX_W-1:0]  partner,
    output logic [ADDR_W-1:0] str_ofs,
    output logic [BYTE_W-1:0] str_len
);
    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    always_comb idx = hdr[IDX_W-1:0];

    // Bits of the port bytes that carry no field
    always_comb unused_bits = ^{b2[6:5], b2[3:0], b3[BYTE_W-1:IDX_W]};

    // Classify the entry and fill the fields that belong to its kind
    always_comb begin
        kind    = K_GEN_OTHER;
        index   = idx;
        link    = 1'b0;
        dual    = 1'b0;
        partner = '0;
        str_ofs = '0;
        str_len = '0;
        if (hdr[HDR_TYPE_BIT]) begin
            if (hdr[HDR_DIS_BIT]) begin
                kind = K_PORT_OFF;
            end else begin
                kind    = K_PORT;
                link    = b2[LINK_BIT];
                dual    = b2[DUAL_BIT];
                partner = b3[IDX_W-1:0];
            end
        end else begin
            if (idx == IDX_W'(1))
                kind = K_VENDOR;
            else if (idx == IDX_W'(2))
                kind = K_DEVICE;
            if (idx == IDX_W'(1) || idx == IDX_W'(2)) begin
                str_ofs = pos + ADDR_W'(2);
                str_len = len - BYTE_W'(2);
            end
        end
    end
endmodule

// File: rtl/ewk_rec_hold.sv
// Record holding register: keeps one record on the output handshake until
// the consumer takes it. A new record may load in the cycle it is taken.
// Assumes the loader only loads when can_load is high.
module ewk_rec_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         can_load
);
    // Space exists when empty or when the held record leaves this cycle
    always_comb can_load = !valid || ready;

    // Load a new record or drop the accepted one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (ld) begin
            valid <= 1'b1;
            data  <= ld_data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));

    // R11
    load_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (!valid || ready));
endmodule

// File: rtl/entry_walker.sv
// Descriptor entry list walker top: sequencer, field decoder and output
// holding register. Emits one record per entry and ends with done or err.
// Assumes a synchronous ROM with one cycle of read latency.
module entry_walker
    import ewk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int START_OFS = 22,
    parameter int PORT_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rom_size,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [2:0]        rec_kind,
    output logic [5:0]        rec_index,
    output logic              rec_link,
    output logic              rec_dual,
    output logic [5:0]        rec_partner,
    output logic [ADDR_W-1:0] rec_str_ofs,
    output logic [7:0]        rec_str_len,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code
);
    localparam int REC_W = 3 + IDX_W + 1 + 1 + IDX_W + ADDR_W + BYTE_W;

    logic              can_load;
    logic              ld;
    logic [ADDR_W-1:0] pos_w;
    logic [BYTE_W-1:0] len_w;
    logic [BYTE_W-1:0] hdr_w;
    logic [BYTE_W-1:0] b2_w;
    logic [BYTE_W-1:0] b3_w;
    ewk_err_e          code_w;
    ewk_kind_e         kind_w;
    logic [IDX_W-1:0]  index_w;
    logic              link_w;
    logic              dual_w;
    logic [IDX_W-1:0]  partner_w;
    logic [ADDR_W-1:0] ofs_w;
    logic [BYTE_W-1:0] slen_w;
    logic [REC_W-1:0]  rec_in;
    logic [REC_W-1:0]  rec_out;

    ewk_walker #(
        .ADDR_W    (ADDR_W),
        .START_OFS (START_OFS),
        .PORT_LEN  (PORT_LEN)
    ) i_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rom_size (rom_size),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .can_load (can_load),
        .ld       (ld),
        .pos_o    (pos_w),
        .len_o    (len_w),
        .hdr_o    (hdr_w),
        .b2_o     (b2_w),
        .b3_o     (b3_w),
        .done     (done),
        .err      (err),
        .err_code (code_w)
    );

    ewk_field_dec #(.ADDR_W(ADDR_W)) i_field_dec (
        .pos     (pos_w),
        .len     (len_w),
        .hdr     (hdr_w),
        .b2      (b2_w),
        .b3      (b3_w),
        .kind    (kind_w),
        .index   (index_w),
        .link    (link_w),
        .dual    (dual_w),
        .partner (partner_w),
        .str_ofs (ofs_w),
        .str_len (slen_w)
    );

    // Pack the decoded fields into one record word
    always_comb rec_in = {kind_w, index_w, link_w, dual_w, partner_w, ofs_w, slen_w};

    ewk_rec_hold #(.W(REC_W)) i_rec_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld),
        .ld_data  (rec_in),
        .ready    (rec_ready),
        .valid    (rec_valid),
        .data     (rec_out),
        .can_load (can_load)
    );

    // Unpack the held record onto the output ports
    always_comb begin
        {rec_kind, rec_index, rec_link, rec_dual, rec_partner,
         rec_str_ofs, rec_str_len} = rec_out;
        err_code = code_w;
    end
endmodule

// File: tb/test_entry_walker.sv
`timescale 1ns/1ps
module test_entry_walker;
    localparam int AW    = 9;
    localparam int START = 22;

    typedef struct packed {
        logic [2:0]    kind;
        logic [5:0]    idx;
        logic          link;
        logic          dual;
        logic [5:0]    partner;
        logic [AW-1:0] ofs;
        logic [7:0]    slen;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] rom_size = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          rec_valid;
    logic          rec_ready;
    logic [2:0]    rec_kind;
    logic [5:0]    rec_index;
    logic          rec_link;
    logic          rec_dual;
    logic [5:0]    rec_partner;
    logic [AW-1:0] rec_str_ofs;
    logic [7:0]    rec_str_len;
    logic          done;
    logic          err;
    logic [2:0]    err_code;

    logic [7:0] mem [0:(1<<AW)-1];
    exp_t       exp_q[$];
    int         checks = 0;
    int         fails = 0;
    int         end_cnt = 0;
    int         end_code = 0;
    int         wp = START;
    bit         stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    entry_walker #(.ADDR_W(AW)) i_entry_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_size(rom_size),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind),
        .rec_index(rec_index), .rec_link(rec_link), .rec_dual(rec_dual),
        .rec_partner(rec_partner), .rec_str_ofs(rec_str_ofs),
        .rec_str_len(rec_str_len), .done(done), .err(err), .err_code(err_code)
    );

    // synchronous ROM, one cycle latency
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: drives ready, pops the scoreboard, notes end pulses
    always @(negedge clk) begin
        exp_t e;
        exp_t a;
        if (!rst_n) begin
            rec_ready = 1'b0;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rec_ready = stall ? lfsr[0] : 1'b1;
            if (rec_valid && rec_ready) begin
                a = {rec_kind, rec_index, rec_link, rec_dual, rec_partner,
                     rec_str_ofs, rec_str_len};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 R12 unexpected record", 64'(a), 64'(0));
                end else begin
                    e = exp_q.pop_front();
                    chk(a == e, "R2 R7 R9 R10 R11 record", 64'(a), 64'(e));
                end
            end
            if (done) begin end_cnt++; end_code = 0; end
            if (err)  begin end_cnt++; end_code = int'(err_code); end
        end
    end

    // reference walk from the requirements; fills the scoreboard
    function automatic int model(int size);
        int p;
        int ln;
        logic [7:0] h;
        exp_t e;
        p = START;
        while (p < size) begin
            ln = int'(mem[p]);
            if (p + 1 == size) return 1;
            if (p + ln > size) return 2;
            if (ln == 0) return 3;
            h = mem[p+1];
            e = '0;
            e.idx = h[5:0];
            if (h[7]) begin
                if (h[6]) e.kind = 3;
                else begin
                    if (ln != 8) return 4;
                    e.kind = 4;
                    e.link = mem[p+2][4];
                    e.dual = mem[p+2][7];
                    e.partner = mem[p+3][5:0];
                end
            end else begin
                e.kind = (h[5:0] == 1) ? 3'd1 : (h[5:0] == 2) ? 3'd2 : 3'd0;
                if (e.kind != 0) begin
                    e.ofs  = AW'(p + 2);
                    e.slen = 8'(ln - 2);
                end
            end
            exp_q.push_back(e);
            p += ln;
        end
        return 0;
    endfunction

    task automatic clear();
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        wp = START;
    endtask

    task automatic ent_gen(int idx, int ln);
        mem[wp] = 8'(ln);
        mem[wp+1] = {2'b00, 6'(idx)};
        for (int k = 2; k < ln; k++) mem[wp+k] = 8'(65 + k);
        wp += ln;
    endtask

    task automatic ent_port(int idx, logic [7:0] b2, logic [7:0] b3);
        mem[wp] = 8'd8;
        mem[wp+1] = {2'b10, 6'(idx)};
        mem[wp+2] = b2;
        mem[wp+3] = b3;
        for (int k = 4; k < 8; k++) mem[wp+k] = 8'h5A;
        wp += 8;
    endtask

    task automatic ent_off(int idx, int ln);
        mem[wp] = 8'(ln);
        mem[wp+1] = {2'b11, 6'(idx)};
        for (int k = 2; k < ln; k++) mem[wp+k] = 8'hFF;
        wp += ln;
    endtask

    task automatic ent_raw(int ln, logic [7:0] hdr);
        mem[wp] = 8'(ln);
        mem[wp+1] = hdr;
        wp += ln;
    endtask

    task automatic run(int size, bit stl, bit restart, string tag);
        int ecode;
        int n;
        ecode = model(size);
        stall = stl;
        end_cnt = 0;
        @(negedge clk); rom_size = AW'(size); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (6) @(negedge clk);
            rom_size = AW'(500); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (end_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
        chk(end_cnt == 1, {tag, " single end pulse"}, 64'(end_cnt), 64'd1);
        chk(end_code == ecode, {tag, " end code"}, 64'(end_code), 64'(ecode));
        chk(exp_q.size() == 0, {tag, " R11 all records seen"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sz;
        clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rec_valid && !done && !err, "R1 reset outputs", 64'({rec_valid, done, err}), 64'd0);

        // R1 empty list: size equal to and below the header
        run(22, 1'b0, 1'b0, "R1 empty");
        run(10, 1'b0, 1'b0, "R1 short rom");

        // R2 R3 R7 R9 R10 mixed list ending exactly on the size
        clear();
        ent_gen(1, 6);
        ent_gen(2, 5);
        ent_gen(9, 3);
        ent_port(1, 8'hB3, 8'hC2);
        ent_port(2, 8'h6F, 8'h3F);
        ent_off(5, 4);
        ent_gen(1, 2);
        sz = wp;
        run(sz, 1'b0, 1'b0, "R3 R9 R10 list");
        run(sz, 1'b1, 1'b0, "R11 stalled list");
        run(sz, 1'b1, 1'b1, "R12 restart ignored");

        // R7 disabled port of bare header length
        clear();
        ent_off(7, 2);
        ent_port(63, 8'h10, 8'h15);
        run(wp, 1'b1, 1'b0, "R7 disabled port");

        // R4 lone last byte
        clear();
        ent_gen(1, 4);
        run(wp + 1, 1'b0, 1'b0, "R4 last byte");

        // R5 overrun
        clear();
        ent_gen(2, 4);
        sz = wp + 5;
        ent_raw(10, 8'h01);
        run(sz, 1'b0, 1'b0, "R5 overrun");

        // R6 zero length
        clear();
        ent_gen(3, 3);
        ent_raw(0, 8'h00);
        run(40, 1'b1, 1'b0, "R6 zero length");

        // R8 enabled port with wrong length
        clear();
        ent_port(3, 8'h80, 8'h01);
        ent_raw(6, 8'h84);
        run(wp + 4, 1'b0, 1'b0, "R8 port length");

        // R12 a fresh start after an error walks normally
        clear();
        ent_gen(2, 7);
        run(wp, 1'b0, 1'b0, "R12 after error");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule